// File: doc/BRIEF.md
# Banked Program Status Register Unit

This block keeps a processor's live status word and one saved copy of it for each privileged exception mode. The live word carries the condition flags, a sticky saturation flag, four per-byte greater-or-equal flags, an endianness bit, abort/IRQ/FIQ masks, two instruction-set state bits and a 5-bit mode field.

Each cycle the ALU may post new flags. The block folds them into the word before anything else acts on it. Exception entry saves that updated word into the target mode's slot and moves the core into the new mode. Exception return reloads the live word from the slot of the active mode. Software may write either the live word or the active slot through a byte-lane mask.

All pins are plain control and status. Every request is taken in the cycle it is presented, so there is no valid/ready pair and no back-pressure. Results show on the read ports one clock edge later. A second, flag-only read port serves application-level code.

Top module: `psr_bank_unit`

## Requirements
- R1: After reset, `cpsr_rd` is 0x000001D3: supervisor mode with A, I and F set. Every saved slot also holds 0x000001D3, and `apsr_rd` is 0.
- R2: The live word places its fields as follows:
  - N, Z, C, V and Q in bits 31..27;
  - J in bit 24;
  - GE[3:0] in bits 19..16;
  - E in bit 9;
  - A, I, F and T in bits 8..5;
  - the mode in bits 4..0.
  Bits 26..25, 23..20 and 15..10 always read 0, and writes to them are dropped.
- R3: `apsr_rd` equals `cpsr_rd` with every bit other than 31..27 and 19..16 forced to 0.
- R4: ALU flag updates work as follows:
  - `alu_flag_we` loads bits 31..28 from `alu_nzcv`;
  - `alu_ge_we` loads bits 19..16 from `alu_ge`;
  - `alu_q_set` sets bit 27.
  Q stays set until a software write or an exception return clears it.
- R5: `cpsr_wr_lanes` bit k enables bits 8k+7..8k of a live-word write. In user mode (10000) only bits 31..27 and 19..16 can change.
- R6: The legal mode codes are:
  - user 10000, FIQ 10001, IRQ 10010, supervisor 10011;
  - abort 10111, undefined 11011, system 11111.
  A write whose mode field is any other code keeps the previous mode and still applies the other enabled bits.
- R7: `exc_take` with a banked target mode in `exc_mode` saves the word into that mode's slot and switches to the target mode. The same entry also:
  - sets I;
  - sets F for FIQ;
  - sets A for FIQ, IRQ and abort;
  - clears T;
  - leaves all other bits unchanged.
  A target of user, system or an illegal code is ignored.
- R8: When an ALU update and an exception entry fall in the same cycle, both the saved copy and the new live word include the ALU update.
- R9: `exc_return` loads the live word from the active mode's slot. In user or system mode it has no effect.
- R10: `spsr_rd` shows the active mode's slot, or 0 in user and system mode. `spsr_wr_en` writes that slot through the `spsr_wr_lanes` mask, with the R2 reserved bits and the R6 mode check applied. In user or system mode no slot changes.
- R11: The order of precedence is:
  - exception entry first, then return, then live-word write;
  - a slot write is dropped in a cycle with an accepted entry;
  - ALU updates are lost when a return is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_flag_we | input | 1 | Load N,Z,C,V from ALU |
| alu_nzcv | input | 4 | New N,Z,C,V |
| alu_q_set | input | 1 | Set sticky saturation flag |
| alu_ge_we | input | 1 | Load GE flags |
| alu_ge | input | 4 | New GE flags |
| exc_take | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the entry |
| exc_return | input | 1 | Restore live word from active slot |
| cpsr_wr_en | input | 1 | Software write of live word |
| cpsr_wr_data | input | 32 | Live-word write data |
| cpsr_wr_lanes | input | 4 | Byte-lane enables for live write |
| spsr_wr_en | input | 1 | Software write of active slot |
| spsr_wr_data | input | 32 | Slot write data |
| spsr_wr_lanes | input | 4 | Byte-lane enables for slot write |
| cpsr_rd | output | 32 | Live status word |
| apsr_rd | output | 32 | Flag-only view |
| spsr_rd | output | 32 | Active mode's saved word, 0 if none |
| ge_flags | output | 4 | GE flags for byte selection |
| cur_mode | output | 5 | Current mode field |

## Verification
The bench drives the following patterns and what each one tells apart:
- **All-ones privileged write.** Separates writable bits from reserved ones.
- **All-ones write in user mode.** Separates flag fields from control fields.
- **Lane-0 write with an illegal mode code.** Shows that the mode guard acts independently of the mask bits around it.
- **Entries into IRQ, FIQ and abort.** Each one exposes a different mix of mask-bit updates. The IRQ entry is paired with a same-cycle ALU update to show which word gets saved.
- **Entry, return and writes in one cycle.** Colliding requests expose the order of precedence.
- **Slot access from system and user mode.** Confirms that no slot is touched from those modes.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = PSR_W / LANE_W;
  localparam int MODE_W    = 5;
  localparam int NUM_BANKS = 5;
  localparam int BANK_IW   = $clog2(NUM_BANKS);

  localparam int POS_Q = 27;
  localparam int POS_A = 8;
  localparam int POS_I = 7;
  localparam int POS_F = 6;
  localparam int POS_T = 5;
  localparam int GE_LO = 16;
  localparam int NZCV_LO = 28;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // writable bits for privileged code, flag-only bits for user code / app view
  localparam logic [PSR_W-1:0] PRIV_MASK = 32'hF90F_03FF;
  localparam logic [PSR_W-1:0] FLAG_MASK = 32'hF80F_0000;
  localparam logic [PSR_W-1:0] RESET_WORD = 32'h0000_01D3;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_banked(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_IW-1:0] mode_slot(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BANK_IW'(0);
      M_IRQ:   return BANK_IW'(1);
      M_SVC:   return BANK_IW'(2);
      M_ABT:   return BANK_IW'(3);
      M_UND:   return BANK_IW'(4);
      default: return BANK_IW'(0);
    endcase
  endfunction
endpackage

// File: rtl/psr_flag_apply.sv
module psr_flag_apply import psr_pkg::*; (
  input  logic [PSR_W-1:0] word_i,
  input  logic             nzcv_we,
  input  logic [3:0]       nzcv,
  input  logic             q_set,
  input  logic             ge_we,
  input  logic [3:0]       ge,
  output logic [PSR_W-1:0] word_o
);
  always_comb begin
    word_o = word_i;
    if (nzcv_we) word_o[NZCV_LO +: 4] = nzcv;
    if (q_set)   word_o[POS_Q] = 1'b1;
    if (ge_we)   word_o[GE_LO +: 4] = ge;
  end
endmodule

// File: rtl/psr_lane_merge.sv
module psr_lane_merge import psr_pkg::*; (
  input  logic [PSR_W-1:0]     old_i,
  input  logic [PSR_W-1:0]     data_i,
  input  logic [NUM_LANES-1:0] lanes_i,
  input  logic [PSR_W-1:0]     allow_i,
  output logic [PSR_W-1:0]     word_o
);
  logic [PSR_W-1:0] raw;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] en;
    assign en = {LANE_W{lanes_i[l]}} & allow_i[l*LANE_W +: LANE_W];
    assign raw[l*LANE_W +: LANE_W] = (data_i[l*LANE_W +: LANE_W] & en)
                                   | (old_i[l*LANE_W +: LANE_W] & ~en);
  end

  // illegal mode codes leave the old mode in place
  always_comb begin
    word_o = raw;
    if (!mode_legal(raw[MODE_W-1:0])) word_o[MODE_W-1:0] = old_i[MODE_W-1:0];
  end
endmodule

// File: rtl/psr_entry_form.sv
module psr_entry_form import psr_pkg::*; (
  input  logic [PSR_W-1:0]  word_i,
  input  logic [MODE_W-1:0] target_i,
  output logic [PSR_W-1:0]  word_o
);
  always_comb begin
    word_o = word_i;
    word_o[MODE_W-1:0] = target_i;
    word_o[POS_I] = 1'b1;
    word_o[POS_T] = 1'b0;
    if (target_i == M_FIQ) word_o[POS_F] = 1'b1;
    if (target_i == M_FIQ || target_i == M_IRQ || target_i == M_ABT)
      word_o[POS_A] = 1'b1;
  end
endmodule

// File: rtl/psr_bank_file.sv
module psr_bank_file import psr_pkg::*; #(
  parameter int NUM = NUM_BANKS,
  parameter int IW  = BANK_IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PSR_W-1:0] wr_data,
  input  logic [IW-1:0]    rd_idx,
  output logic [PSR_W-1:0] rd_data
);
  logic [NUM-1:0][PSR_W-1:0] slots;

  for (genvar b = 0; b < NUM; b++) begin : g_slot
    logic [PSR_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            slot_q <= RESET_WORD;
      else if (wr_en && wr_idx == IW'(b))    slot_q <= wr_data;
    end
    assign slots[b] = slot_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++)
      if (rd_idx == IW'(i)) rd_data = slots[i];
  end

  // R10: with no write request no slot may change
  a_r10_slots_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(slots));
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit import psr_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alu_flag_we,
  input  logic [3:0]           alu_nzcv,
  input  logic                 alu_q_set,
  input  logic                 alu_ge_we,
  input  logic [3:0]           alu_ge,
  input  logic                 exc_take,
  input  logic [MODE_W-1:0]    exc_mode,
  input  logic                 exc_return,
  input  logic                 cpsr_wr_en,
  input  logic [PSR_W-1:0]     cpsr_wr_data,
  input  logic [NUM_LANES-1:0] cpsr_wr_lanes,
  input  logic                 spsr_wr_en,
  input  logic [PSR_W-1:0]     spsr_wr_data,
  input  logic [NUM_LANES-1:0] spsr_wr_lanes,
  output logic [PSR_W-1:0]     cpsr_rd,
  output logic [PSR_W-1:0]     apsr_rd,
  output logic [PSR_W-1:0]     spsr_rd,
  output logic [3:0]           ge_flags,
  output logic [MODE_W-1:0]    cur_mode
);
  logic [PSR_W-1:0]   live_q, live_d;
  logic [PSR_W-1:0]   flagged, entered, sw_live, sw_slot, slot_rd, slot_wdata;
  logic [BANK_IW-1:0] cur_slot, slot_widx;
  logic               cur_has_slot, take_ok, ret_ok, slot_we, user_mode;

  assign cur_has_slot = mode_banked(live_q[MODE_W-1:0]);
  assign cur_slot     = mode_slot(live_q[MODE_W-1:0]);
  assign user_mode    = (live_q[MODE_W-1:0] == M_USR);
  assign take_ok      = exc_take && mode_banked(exc_mode);
  assign ret_ok       = exc_return && cur_has_slot && !take_ok;

  psr_flag_apply u_flags (
    .word_i(live_q), .nzcv_we(alu_flag_we), .nzcv(alu_nzcv),
    .q_set(alu_q_set), .ge_we(alu_ge_we), .ge(alu_ge), .word_o(flagged)
  );

  psr_entry_form u_entry (
    .word_i(flagged), .target_i(exc_mode), .word_o(entered)
  );

  psr_lane_merge u_live_wr (
    .old_i(flagged), .data_i(cpsr_wr_data), .lanes_i(cpsr_wr_lanes),
    .allow_i(user_mode ? FLAG_MASK : PRIV_MASK), .word_o(sw_live)
  );

  psr_lane_merge u_slot_wr (
    .old_i(slot_rd), .data_i(spsr_wr_data), .lanes_i(spsr_wr_lanes),
    .allow_i(PRIV_MASK), .word_o(sw_slot)
  );

  // slot write port: entry save has precedence over software writes
  always_comb begin
    slot_we    = 1'b0;
    slot_widx  = cur_slot;
    slot_wdata = sw_slot;
    if (take_ok) begin
      slot_we    = 1'b1;
      slot_widx  = mode_slot(exc_mode);
      slot_wdata = flagged;
    end else if (spsr_wr_en && cur_has_slot) begin
      slot_we = 1'b1;
    end
  end

  psr_bank_file u_banks (
    .clk(clk), .rst_n(rst_n), .wr_en(slot_we), .wr_idx(slot_widx),
    .wr_data(slot_wdata), .rd_idx(cur_slot), .rd_data(slot_rd)
  );

  always_comb begin
    if (take_ok)         live_d = entered;
    else if (ret_ok)     live_d = slot_rd;
    else if (cpsr_wr_en) live_d = sw_live;
    else                 live_d = flagged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= RESET_WORD;
    else        live_q <= live_d;
  end

  assign cpsr_rd  = live_q;
  assign apsr_rd  = live_q & FLAG_MASK;
  assign spsr_rd  = cur_has_slot ? slot_rd : '0;
  assign ge_flags = live_q[GE_LO +: 4];
  assign cur_mode = live_q[MODE_W-1:0];

  // R2: reserved bits of the live word never become set
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_rd & ~PRIV_MASK) == '0);
  // R6: the mode field only ever holds a legal code
  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(cur_mode));
  // R7: an accepted entry lands in the target mode with I set and T clear
  a_r7_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |=> (cur_mode == $past(exc_mode)) && cpsr_rd[POS_I] && !cpsr_rd[POS_T]);
  // R4: Q is sticky unless software writes or a return reloads the word
  a_r4_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_rd[POS_Q] && !cpsr_wr_en && !ret_ok) |=> cpsr_rd[POS_Q]);
endmodule

// File: tb/psr_bank_unit_tb_top.sv
`timescale 1ns/1ps
module psr_bank_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_fwe = 0, s_q = 0, s_gwe = 0, s_take = 0, s_ret = 0, s_cwr = 0, s_swr = 0;
  logic [3:0]  s_nzcv = 0, s_ge = 0, s_clanes = 0, s_slanes = 0;
  logic [4:0]  s_emode = 0;
  logic [31:0] s_cdata = 0, s_sdata = 0;
  logic [31:0] cpsr_rd, apsr_rd, spsr_rd;
  logic [3:0]  ge_flags;
  logic [4:0]  cur_mode;

  always #2.5 clk = ~clk;

  psr_bank_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .alu_flag_we(s_fwe), .alu_nzcv(s_nzcv), .alu_q_set(s_q),
    .alu_ge_we(s_gwe), .alu_ge(s_ge),
    .exc_take(s_take), .exc_mode(s_emode), .exc_return(s_ret),
    .cpsr_wr_en(s_cwr), .cpsr_wr_data(s_cdata), .cpsr_wr_lanes(s_clanes),
    .spsr_wr_en(s_swr), .spsr_wr_data(s_sdata), .spsr_wr_lanes(s_slanes),
    .cpsr_rd(cpsr_rd), .apsr_rd(apsr_rd), .spsr_rd(spsr_rd),
    .ge_flags(ge_flags), .cur_mode(cur_mode)
  );

  typedef struct {
    logic [31:0] c;
    logic [31:0] s;
    logic [31:0] a;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // ---- reference model built from the requirements ----
  logic [31:0] m_cur;
  logic [31:0] m_slot [5];

  function automatic bit m_legal(logic [4:0] m);
    return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011 ||
           m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
  endfunction
  function automatic bit m_banked(logic [4:0] m);
    return m_legal(m) && m != 5'b10000 && m != 5'b11111;
  endfunction
  function automatic int m_idx(logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      default:  return 4;
    endcase
  endfunction
  function automatic logic [31:0] m_merge(logic [31:0] old, logic [31:0] d,
                                          logic [3:0] lanes, logic [31:0] allow);
    logic [31:0] en, r;
    en = {{8{lanes[3]}}, {8{lanes[2]}}, {8{lanes[1]}}, {8{lanes[0]}}} & allow;
    r = (d & en) | (old & ~en);
    if (!m_legal(r[4:0])) r[4:0] = old[4:0];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_spsr(logic [31:0] w);
    return m_banked(w[4:0]) ? m_slot[m_idx(w[4:0])] : 32'h0;
  endfunction

  // driver: computes the expected result of the staged stimulus, applies one edge
  task automatic tick(string tag);
    logic [31:0] f, nc, old;
    bit cb, take;
    exp_t e;
    f = m_cur;
    if (s_fwe) f[31:28] = s_nzcv;
    if (s_q)   f[27] = 1'b1;
    if (s_gwe) f[19:16] = s_ge;
    cb   = m_banked(m_cur[4:0]);
    old  = cb ? m_slot[m_idx(m_cur[4:0])] : 32'h0;
    take = s_take && m_banked(s_emode);
    if (take) begin
      m_slot[m_idx(s_emode)] = f;
      nc = f;
      nc[4:0] = s_emode;
      nc[7] = 1'b1;
      nc[5] = 1'b0;
      if (s_emode == 5'b10001) nc[6] = 1'b1;
      if (s_emode == 5'b10001 || s_emode == 5'b10010 || s_emode == 5'b10111) nc[8] = 1'b1;
    end else begin
      if (s_swr && cb) m_slot[m_idx(m_cur[4:0])] = m_merge(old, s_sdata, s_slanes, 32'hF90F03FF);
      if (s_ret && cb)  nc = old;
      else if (s_cwr)   nc = m_merge(f, s_cdata, s_clanes,
                                     (m_cur[4:0] == 5'b10000) ? 32'hF80F0000 : 32'hF90F03FF);
      else              nc = f;
    end
    m_cur = nc;
    @(posedge clk);
    #1;
    e.c = nc; e.s = m_spsr(nc); e.a = nc & 32'hF80F0000; e.tag = tag;
    sb.push_back(e);
    s_fwe = 0; s_q = 0; s_gwe = 0; s_take = 0; s_ret = 0; s_cwr = 0; s_swr = 0;
  endtask

  // monitor: compares design outputs against queued expectations
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " cpsr"}, cpsr_rd, e.c);
      chk({e.tag, " spsr"}, spsr_rd, e.s);
      chk({e.tag, " apsr"}, apsr_rd, e.a);
      chk({e.tag, " ge"}, {28'h0, ge_flags}, {28'h0, e.c[19:16]});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    exp_t e;
    m_cur = 32'h0000_01D3;
    for (int i = 0; i < 5; i++) m_slot[i] = 32'h0000_01D3;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    e.c = 32'h0000_01D3; e.s = 32'h0000_01D3; e.a = 32'h0; e.tag = "R1 reset";
    sb.push_back(e);
    @(posedge clk); #1;

    s_fwe = 1; s_nzcv = 4'hA; s_q = 1; s_gwe = 1; s_ge = 4'h5;
    tick("R4 alu flags");
    s_fwe = 1; s_nzcv = 4'h0;
    tick("R4 q sticky");
    @(negedge clk) chk("R4 q still set", {31'h0, cpsr_rd[27]}, 32'h1);
    @(posedge clk); #1;

    s_cwr = 1; s_cdata = 32'hFFFF_FFFF; s_clanes = 4'hF;
    tick("R2 R3 all-ones privileged write");
    @(negedge clk) begin
      chk("R2 reserved bits", cpsr_rd, 32'hF90F_03FF);
      chk("R3 flag view", apsr_rd, 32'hF80F_0000);
    end
    @(posedge clk); #1;

    s_swr = 1; s_sdata = 32'h0; s_slanes = 4'hF; s_ret = 1;
    tick("R9 R10 system mode has no slot");

    s_cwr = 1; s_cdata = 32'h0000_0013; s_clanes = 4'h1;
    tick("R5 lane0 write to supervisor");
    s_cwr = 1; s_cdata = 32'h0000_00E5; s_clanes = 4'h1;
    tick("R6 illegal mode kept");
    @(negedge clk) chk("R6 mode field", cpsr_rd, 32'hF90F_03F3);
    @(posedge clk); #1;

    s_take = 1; s_emode = 5'b10010; s_fwe = 1; s_nzcv = 4'h5;
    tick("R7 R8 irq entry with alu update");
    @(negedge clk) begin
      chk("R8 saved word", spsr_rd, 32'h590F_03F3);
      chk("R7 irq live word", cpsr_rd, 32'h590F_03D2);
    end
    @(posedge clk); #1;

    s_swr = 1; s_sdata = 32'h0; s_slanes = 4'h8;
    tick("R10 slot lane write");
    s_ret = 1;
    tick("R9 return");

    s_cwr = 1; s_cdata = 32'h0000_0010; s_clanes = 4'h1;
    tick("R5 drop to user");
    s_cwr = 1; s_cdata = 32'hFFFF_FFFF; s_clanes = 4'hF;
    tick("R5 user write limited");
    @(negedge clk) chk("R5 user write", cpsr_rd, 32'hF80F_0310);
    @(posedge clk); #1;

    s_take = 1; s_emode = 5'b10000;
    tick("R7 user target ignored");
    s_take = 1; s_emode = 5'b00101;
    tick("R7 illegal target ignored");
    s_swr = 1; s_sdata = 32'hFFFF_FFFF; s_slanes = 4'hF;
    tick("R10 user mode slot write ignored");

    s_take = 1; s_emode = 5'b10001;
    tick("R7 fiq entry");
    s_take = 1; s_emode = 5'b10111; s_cwr = 1; s_cdata = 32'h0; s_clanes = 4'hF;
    s_swr = 1; s_sdata = 32'h0; s_slanes = 4'hF;
    tick("R11 entry beats writes");
    @(negedge clk) chk("R11 abort live word", cpsr_rd, 32'hF80F_03D7);
    @(posedge clk); #1;

    s_ret = 1; s_cwr = 1; s_cdata = 32'h0; s_clanes = 4'hF;
    tick("R11 return beats write");
    s_ret = 1; s_fwe = 1; s_nzcv = 4'h3;
    tick("R9 R11 return to user drops alu");

    s_gwe = 1; s_ge = 4'hA;
    tick("R4 ge in user");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule